// File: doc/BRIEF.md
# Response Ring Writer with Interrupt Coalescing

This block is the controller-side engine that stores codec responses into an inbound circular buffer in system memory. Each response arrives with a 32-bit payload, a 4-bit codec address and a flag that marks an unsolicited event. The block turns each one into an 8-byte ring entry. The entry is written as two 32-bit memory writes: first the payload, then an extended word that carries the address and the flag. After both writes, a hardware write pointer moves to name the slot just filled. The ring has 2**PTR_W slots, 256 by default, and its pointer wraps.

Software drives the block through a small write port with four targets:

- a pointer control, whose top bit returns the pointer to zero;
- a response-count threshold;
- a control word with separate DMA-enable and interrupt-enable bits;
- a write-1-to-clear status flag.

The status flag sets each time the programmed number of entries has been stored. The interrupt output is the status flag gated by the interrupt enable. When DMA is switched off, an entry already in flight completes, and the busy indication holds until it does.

The entry engine is a three-state machine: `S_IDLE`, `S_PAYLOAD` and `S_EXTEND`.

- ACCEPT goes from `S_IDLE` to `S_PAYLOAD` when a response is offered and DMA is enabled.
- DROP stays in `S_IDLE` when a response is offered with DMA disabled. The response is consumed and discarded.
- STORE_LO goes from `S_PAYLOAD` to `S_EXTEND` unconditionally, after the payload write.
- STORE_HI goes from `S_EXTEND` back to `S_IDLE` unconditionally, after the extended write. It also commits the pointer and counts the entry.

Top module: `resp_ring_writer`

## Requirements
- R1: Each stored entry is two memory writes in consecutive cycles. The first write puts the payload at byte address slot*8. The second puts the extended word at slot*8+4. The extended word holds the codec address in bits [3:0], the unsolicited flag in bit 4 and zeros above.
- R2: The slot used is the write pointer plus one, so the first entry after reset goes to slot 1. The pointer takes the slot's value in the cycle after the extended write, so it always names the last entry written.
- R3: Slot numbers and the pointer wrap modulo 2**PTR_W. The entry after slot 255 goes to slot 0.
- R4: A register write with reg_sel=0 and reg_wdata[8]=1 returns the write pointer to 0.
- R5: With threshold N (reg_sel=1, reg_wdata[7:0], reset value 1), the status flag sets when the N-th stored entry completes. N=0 means 256.
- R6: The entry counter returns to zero when the threshold is reached and whenever the threshold register is written.
- R7: The status flag clears on a write with reg_sel=3 and reg_wdata[0]=1. Writing 0 there leaves it unchanged. irq equals the status flag ANDed with the interrupt enable (reg_sel=2, bit 0).
- R8: With DMA disabled (reg_sel=2, bit 1 = 0), offered responses are consumed without any memory write, and the pointer and status flag do not change.
- R9: dma_active is 1 while DMA is enabled or an entry is in flight. After DMA is disabled mid-entry, the entry still completes and dma_active falls only when the block is back in `S_IDLE`.
- R10: After reset, the pointer is 0, the status flag, irq, dma_active and mem_we are 0, and DMA and interrupts are disabled.
- R11: rsp_ready is 1 only in `S_IDLE`. It is 0 while either half of an entry is being written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rsp_valid | input | 1 | Response offered |
| rsp_ready | output | 1 | Response taken this cycle when valid |
| rsp_payload | input | 32 | Response payload |
| rsp_caddr | input | 4 | Responding codec address |
| rsp_unsol | input | 1 | Unsolicited-event flag |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Target: 0 pointer, 1 threshold, 2 control, 3 status |
| reg_wdata | input | PTR_W+1 | Register write data |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | PTR_W+3 | Byte offset within the ring |
| mem_wdata | output | 32 | Memory write data |
| wr_ptr | output | PTR_W | Slot of the last written entry |
| dma_active | output | 1 | DMA enabled or entry in flight |
| status_flag | output | 1 | Response threshold reached, write 1 to clear |
| irq | output | 1 | Response interrupt |

## Verification
A wrong pointer or a wrong latched slot appears on mem_addr in the cycle after acceptance, and on wr_ptr two cycles later. A scoreboard compares every memory write, so no entry can slip through with a bad address or a bad extended word. A miscounting coalescing counter only shows itself on the status flag at the next N-th entry. For that reason, the threshold tests read the flag after every entry, both just before and just at the limit. A stuck or early-closing state machine shows at once on rsp_ready and dma_active, which are read during each half of an entry.

// File: rtl/ring_pkg.sv
package ring_pkg;
    typedef enum logic [1:0] {
        SEL_WPTR   = 2'd0,
        SEL_COUNT  = 2'd1,
        SEL_CTRL   = 2'd2,
        SEL_STATUS = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        S_IDLE    = 2'd0,
        S_PAYLOAD = 2'd1,
        S_EXTEND  = 2'd2
    } wr_state_e;

    localparam int CADDR_W       = 4;
    localparam int DATA_W        = 32;
    localparam int CTRL_IRQ_BIT  = 0;
    localparam int CTRL_DMA_BIT  = 1;
    localparam int STS_CLR_BIT   = 0;
endpackage

// File: rtl/ring_ctl_regs.sv
module ring_ctl_regs
    import ring_pkg::*;
#(
    parameter int PTR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic [1:0]       reg_sel,
    input  logic [PTR_W:0]   reg_wdata,
    input  logic             thresh_hit,
    output logic             dma_en,
    output logic             irq_en,
    output logic [PTR_W-1:0] thresh,
    output logic             status,
    output logic             ptr_clr,
    output logic             cnt_clr
);
    logic sts_clr;

    always_comb begin
        ptr_clr = reg_we && (reg_sel == SEL_WPTR) && reg_wdata[PTR_W];
        cnt_clr = reg_we && (reg_sel == SEL_COUNT);
        sts_clr = reg_we && (reg_sel == SEL_STATUS) && reg_wdata[STS_CLR_BIT];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dma_en <= 1'b0;
            irq_en <= 1'b0;
            thresh <= PTR_W'(1);
            status <= 1'b0;
        end else begin
            if (reg_we && reg_sel == SEL_CTRL) begin
                dma_en <= reg_wdata[CTRL_DMA_BIT];
                irq_en <= reg_wdata[CTRL_IRQ_BIT];
            end
            if (cnt_clr)
                thresh <= reg_wdata[PTR_W-1:0];
            if (thresh_hit)
                status <= 1'b1;
            else if (sts_clr)
                status <= 1'b0;
        end
    end

    // R7: a clear request without a simultaneous hit empties the flag
    a_r7_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_clr && !thresh_hit) |=> !status);
    // R5: a threshold hit always leaves the flag set
    a_r5_hit_sets: assert property (@(posedge clk) disable iff (!rst_n)
        thresh_hit |=> status);
endmodule

// File: rtl/ring_coalesce.sv
module ring_coalesce #(
    parameter int PTR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             entry_done,
    input  logic             cnt_clr,
    input  logic [PTR_W-1:0] thresh,
    output logic             hit
);
    logic [PTR_W-1:0] count;
    logic [PTR_W-1:0] count_inc;

    always_comb begin
        count_inc = count + 1'b1;
        hit       = entry_done && (count_inc == thresh);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (cnt_clr || hit)
            count <= '0;
        else if (entry_done)
            count <= count_inc;
    end

    // R6: writing the threshold restarts the count
    a_r6_cnt_restart: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_clr |=> (count == '0));
    // R6: no completed entry leaves the count unchanged
    a_r6_cnt_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!entry_done && !cnt_clr) |=> $stable(count));
endmodule

// File: rtl/ring_entry_fsm.sv
module ring_entry_fsm
    import ring_pkg::*;
#(
    parameter int PTR_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               dma_en,
    input  logic               ptr_clr,
    input  logic               rsp_valid,
    input  logic [DATA_W-1:0]  rsp_payload,
    input  logic [CADDR_W-1:0] rsp_caddr,
    input  logic               rsp_unsol,
    output logic               rsp_ready,
    output logic               mem_we,
    output logic [PTR_W+2:0]   mem_addr,
    output logic [DATA_W-1:0]  mem_wdata,
    output logic [PTR_W-1:0]   wr_ptr,
    output logic               entry_done,
    output logic               busy
);
    wr_state_e          state, state_nx;
    logic [PTR_W-1:0]   slot;
    logic [DATA_W-1:0]  payload_q;
    logic [CADDR_W-1:0] caddr_q;
    logic               unsol_q;
    logic               accept;

    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= S_IDLE;
        else
            state <= state_nx;
    end

    always_comb begin
        state_nx   = state;
        rsp_ready  = 1'b0;
        mem_we     = 1'b0;
        mem_addr   = '0;
        mem_wdata  = '0;
        entry_done = 1'b0;
        accept     = 1'b0;
        unique case (state)
            S_IDLE: begin
                rsp_ready = 1'b1;
                if (rsp_valid && dma_en) begin
                    accept   = 1'b1;
                    state_nx = S_PAYLOAD;
                end
            end
            S_PAYLOAD: begin
                mem_we    = 1'b1;
                mem_addr  = {slot, 3'b000};
                mem_wdata = payload_q;
                state_nx  = S_EXTEND;
            end
            S_EXTEND: begin
                mem_we     = 1'b1;
                mem_addr   = {slot, 3'b100};
                mem_wdata  = DATA_W'({unsol_q, caddr_q});
                entry_done = 1'b1;
                state_nx   = S_IDLE;
            end
            default: state_nx = S_IDLE;
        endcase
        busy = (state != S_IDLE);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot      <= '0;
            payload_q <= '0;
            caddr_q   <= '0;
            unsol_q   <= 1'b0;
            wr_ptr    <= '0;
        end else begin
            if (accept) begin
                slot      <= wr_ptr + 1'b1;
                payload_q <= rsp_payload;
                caddr_q   <= rsp_caddr;
                unsol_q   <= rsp_unsol;
            end
            if (ptr_clr)
                wr_ptr <= '0;
            else if (entry_done)
                wr_ptr <= slot;
        end
    end

    // R1: a payload write is followed by the extended write to the same slot
    a_r1_pair: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && !mem_addr[2]) |=> (mem_we && mem_addr[2] &&
            mem_addr[PTR_W+2:3] == $past(mem_addr[PTR_W+2:3])));
    // R8: with DMA off and nothing in flight the pointer stays put
    a_r8_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && !dma_en && !ptr_clr) |=> $stable(wr_ptr));
    // R11: no response is taken while an entry is being written
    a_r11_no_ready_busy: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !rsp_ready);
endmodule

// File: rtl/resp_ring_writer.sv
module resp_ring_writer
    import ring_pkg::*;
#(
    parameter int PTR_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rsp_valid,
    output logic               rsp_ready,
    input  logic [31:0]        rsp_payload,
    input  logic [3:0]         rsp_caddr,
    input  logic               rsp_unsol,
    input  logic               reg_we,
    input  logic [1:0]         reg_sel,
    input  logic [PTR_W:0]     reg_wdata,
    output logic               mem_we,
    output logic [PTR_W+2:0]   mem_addr,
    output logic [31:0]        mem_wdata,
    output logic [PTR_W-1:0]   wr_ptr,
    output logic               dma_active,
    output logic               status_flag,
    output logic               irq
);
    localparam int ADDR_W = PTR_W + 3;

    logic             dma_en, irq_en, ptr_clr, cnt_clr;
    logic             entry_done, busy, hit;
    logic [PTR_W-1:0] thresh;

    ring_ctl_regs #(.PTR_W(PTR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .thresh_hit(hit), .dma_en(dma_en),
        .irq_en(irq_en), .thresh(thresh), .status(status_flag),
        .ptr_clr(ptr_clr), .cnt_clr(cnt_clr)
    );

    ring_coalesce #(.PTR_W(PTR_W)) u_coal (
        .clk(clk), .rst_n(rst_n), .entry_done(entry_done),
        .cnt_clr(cnt_clr), .thresh(thresh), .hit(hit)
    );

    ring_entry_fsm #(.PTR_W(PTR_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .dma_en(dma_en), .ptr_clr(ptr_clr),
        .rsp_valid(rsp_valid), .rsp_payload(rsp_payload),
        .rsp_caddr(rsp_caddr), .rsp_unsol(rsp_unsol),
        .rsp_ready(rsp_ready), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .wr_ptr(wr_ptr),
        .entry_done(entry_done), .busy(busy)
    );

    always_comb begin
        dma_active = dma_en || busy;
        irq        = status_flag && irq_en;
    end

    // R2: the pointer lands on the slot of the extended write just made
    a_r2_ptr_names_last: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && mem_addr[2] && !ptr_clr) |=>
            (wr_ptr == $past(mem_addr[ADDR_W-1:3])));
    // R9: memory is never written while the block reports itself idle
    a_r9_active_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> dma_active);
    // R7: interrupt never rises without the status flag
    a_r7_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> status_flag);
endmodule

// File: tb/resp_ring_writer_bench.sv
module resp_ring_writer_bench;
    localparam int PTR_W = 8;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               rsp_valid = 1'b0;
    logic               rsp_ready;
    logic [31:0]        rsp_payload = '0;
    logic [3:0]         rsp_caddr = '0;
    logic               rsp_unsol = 1'b0;
    logic               reg_we = 1'b0;
    logic [1:0]         reg_sel = '0;
    logic [PTR_W:0]     reg_wdata = '0;
    logic               mem_we;
    logic [PTR_W+2:0]   mem_addr;
    logic [31:0]        mem_wdata;
    logic [PTR_W-1:0]   wr_ptr;
    logic               dma_active, status_flag, irq;

    int n_checks = 0;
    int n_fail   = 0;
    logic [PTR_W+2:0] q_addr[$];
    logic [31:0]      q_data[$];
    logic [PTR_W-1:0] exp_ptr = '0;
    bit               dma_on = 1'b0;

    always #10 clk = ~clk;

    resp_ring_writer #(.PTR_W(PTR_W)) u_resp_ring_writer (
        .clk(clk), .rst_n(rst_n), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .rsp_payload(rsp_payload), .rsp_caddr(rsp_caddr), .rsp_unsol(rsp_unsol),
        .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .wr_ptr(wr_ptr), .dma_active(dma_active), .status_flag(status_flag),
        .irq(irq)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    // monitor: every memory write must match the head of the scoreboard (R1, R2)
    always @(negedge clk) begin
        if (rst_n && mem_we) begin
            if (q_addr.size() == 0) begin
                n_checks++;
                n_fail++;
                $display("FAIL R8: got write %h@%h expected none", mem_wdata, mem_addr);
            end else begin
                check("R1 addr", 32'(mem_addr), 32'(q_addr.pop_front()));
                check("R1 data", mem_wdata, q_data.pop_front());
            end
        end
    end

    task automatic reg_write(logic [1:0] sel, logic [PTR_W:0] data);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = data;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic send(logic [31:0] pl, logic [3:0] ca, logic un);
        while (!rsp_ready) @(negedge clk);
        rsp_valid = 1'b1; rsp_payload = pl; rsp_caddr = ca; rsp_unsol = un;
        if (dma_on) begin
            exp_ptr = exp_ptr + 1'b1;
            q_addr.push_back({exp_ptr, 3'b000});
            q_data.push_back(pl);
            q_addr.push_back({exp_ptr, 3'b100});
            q_data.push_back({27'b0, un, ca});
        end
        @(negedge clk);
        rsp_valid = 1'b0;
        if (dma_on) begin
            @(negedge clk);
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        check("R10 ptr", 32'(wr_ptr), 0);
        check("R10 status", 32'(status_flag), 0);
        check("R10 irq", 32'(irq), 0);
        check("R10 active", 32'(dma_active), 0);
        check("R10 mem_we", 32'(mem_we), 0);

        // enable DMA and interrupt; default threshold 1 (R5)
        reg_write(2'd2, 9'b11); dma_on = 1'b1;
        send(32'hCAFE_0001, 4'h2, 1'b0);
        check("R2 first ptr", 32'(wr_ptr), 1);
        check("R5 thr1 status", 32'(status_flag), 1);
        check("R7 irq on", 32'(irq), 1);

        // R7 write-1-to-clear
        reg_write(2'd3, 9'd0);
        check("R7 zero no effect", 32'(status_flag), 1);
        reg_write(2'd3, 9'd1);
        check("R7 cleared", 32'(status_flag), 0);
        check("R7 irq off", 32'(irq), 0);

        // R7 interrupt gating, R1 unsolicited bit
        reg_write(2'd2, 9'b10);
        send(32'h1234_5678, 4'hF, 1'b1);
        check("R7 status masked", 32'(status_flag), 1);
        check("R7 irq masked", 32'(irq), 0);
        reg_write(2'd3, 9'd1);
        reg_write(2'd2, 9'b11);

        // R5 threshold of 3
        reg_write(2'd1, 9'd3);
        send(32'hA0, 4'h1, 1'b0);
        send(32'hA1, 4'h1, 1'b0);
        check("R5 below limit", 32'(status_flag), 0);
        send(32'hA2, 4'h1, 1'b0);
        check("R5 at limit", 32'(status_flag), 1);
        reg_write(2'd3, 9'd1);

        // R6 counter restarts after hit and on threshold write
        send(32'hB0, 4'h3, 1'b0);
        send(32'hB1, 4'h3, 1'b0);
        check("R6 after hit", 32'(status_flag), 0);
        reg_write(2'd1, 9'd3);
        send(32'hB2, 4'h3, 1'b0);
        send(32'hB3, 4'h3, 1'b0);
        check("R6 after rewrite", 32'(status_flag), 0);
        send(32'hB4, 4'h3, 1'b0);
        check("R6 third after rewrite", 32'(status_flag), 1);
        reg_write(2'd3, 9'd1);

        // R8 DMA off drops responses
        reg_write(2'd1, 9'd1);
        reg_write(2'd2, 9'b01); dma_on = 1'b0;
        send(32'hDEAD_0000, 4'h4, 1'b0);
        repeat (3) @(negedge clk);
        check("R8 ptr held", 32'(wr_ptr), 32'(exp_ptr));
        check("R8 status held", 32'(status_flag), 0);
        check("R9 idle when off", 32'(dma_active), 0);

        // R9 drain after disable mid-entry, R11 ready low while busy
        reg_write(2'd2, 9'b11); dma_on = 1'b1;
        check("R11 ready idle", 32'(rsp_ready), 1);
        rsp_valid = 1'b1; rsp_payload = 32'hC0DE_0001; rsp_caddr = 4'h5; rsp_unsol = 1'b0;
        exp_ptr = exp_ptr + 1'b1;
        q_addr.push_back({exp_ptr, 3'b000}); q_data.push_back(32'hC0DE_0001);
        q_addr.push_back({exp_ptr, 3'b100}); q_data.push_back(32'h5);
        @(negedge clk);
        rsp_valid = 1'b0;
        check("R11 ready busy", 32'(rsp_ready), 0);
        reg_we = 1'b1; reg_sel = 2'd2; reg_wdata = 9'b01; dma_on = 1'b0;
        @(negedge clk);
        reg_we = 1'b0;
        check("R9 still active", 32'(dma_active), 1);
        check("R11 ready second half", 32'(rsp_ready), 0);
        @(negedge clk);
        check("R9 idle after drain", 32'(dma_active), 0);
        check("R9 entry committed", 32'(wr_ptr), 32'(exp_ptr));
        reg_write(2'd3, 9'd1);

        // R4 pointer reset
        reg_write(2'd0, 9'h100);
        exp_ptr = '0;
        check("R4 ptr reset", 32'(wr_ptr), 0);

        // R3 wrap with threshold 0 meaning 256 (R5)
        reg_write(2'd2, 9'b11); dma_on = 1'b1;
        reg_write(2'd1, 9'd0);
        for (int i = 0; i < 255; i++)
            send(32'h5000_0000 + 32'(i), 4'(i), 1'b0);
        check("R3 ptr 255", 32'(wr_ptr), 255);
        check("R5 256 not reached", 32'(status_flag), 0);
        send(32'h5000_00FF, 4'h7, 1'b1);
        check("R3 wrapped ptr", 32'(wr_ptr), 0);
        check("R5 256 reached", 32'(status_flag), 1);

        @(negedge clk);
        check("R1 scoreboard empty", 32'(q_addr.size()), 0);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule